// File: doc/BRIEF.md
# Shadowed Memory Store/Recall Controller

This block owns a byte-wide working memory and a shadow copy of the same depth, which stands in for a nonvolatile array. In normal operation the host reads and writes the working memory. A store copies the whole working memory into the shadow. A recall restores the working memory from the shadow. Both move every location at once, and while either one runs the host sees an inert memory.

There are three request sources. A rising edge on the power-fail input asks for an automatic store. That store runs only if the host has written something since the last completed transfer. A software pulse asks for a store that always runs. A rising edge on the power-good input asks for a recall, and a recall also runs by itself when reset is released, which models power-up.

Each transfer has two phases counted in clock cycles. A store wipes the shadow and then programs it. A recall wipes the working memory and then refills it. A busy output covers the full length of each transfer, and a dirty output shows whether the host has written since the last transfer.

Top module: `shadow_mem_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and `dirty` is 0. Reset starts a recall. `busy` falls at the RECALL_CYC-th rising clock edge after `rst_n` goes high. The working memory then equals the shadow, which reset leaves untouched.
- R2: While idle, a host access with `host_en`=1 and `host_we`=1 writes `host_wdata` at `host_addr` on the clock edge. With `host_en`=1 and `host_we`=0, `host_rdata` shows the word at `host_addr` in the same cycle. In every other case `host_rdata` is 0.
- R3: While `busy` is 1, `host_rdata` is 0 and host writes are discarded.
- R4: An accepted host write sets `dirty` to 1. The completion of any store or recall clears it.
- R5: If `dirty` is 1 when `pwr_fail` rises, a store runs. At the end of the store the shadow holds the working memory contents.
- R6: If `dirty` is 0 when `pwr_fail` rises, no store runs and `busy` stays 0.
- R7: A one-cycle `sw_store` pulse while idle starts a store whether or not `dirty` is set.
- R8: A rise of `pwr_good` while idle starts a recall. The working memory is cleared and then loaded from the shadow, so writes made after the last store are lost. A recall never changes the shadow.
- R9: If `pwr_good` rises while `busy` is 1, the recall is held. It starts one idle cycle after the running transfer ends. A `sw_store` or `pwr_fail` rise during `busy` is dropped.
- R10: If several requests arrive in the same idle cycle, a recall wins over an automatic store, and an automatic store wins over a software store. Requests that lose are dropped.
- R11: A store keeps `busy` high for exactly STORE_CYC cycles and a recall for exactly RECALL_CYC cycles, counted from the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| host_en | input | 1 | Host access valid |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, 0 when not reading or busy |
| pwr_fail | input | 1 | Supply below threshold (level) |
| pwr_good | input | 1 | Supply restored (level) |
| sw_store | input | 1 | Software store request pulse |
| busy | output | 1 | Transfer in progress |
| dirty | output | 1 | Written since last completed transfer |

## Verification
The bench builds the block with ADDR_W=4, STORE_CYC=40 and RECALL_CYC=6. At these values the bench can read back all sixteen words after every recall. It can also count the full length of each busy window against its exact expected value. Because the store is short, the bench can place a held recall, discarded writes and a dropped software request inside one store and still observe each outcome at the ports.

// File: rtl/shadow_mem_ctrl.sv
module shadow_mem_ctrl #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int STORE_CYC  = 2000,
  parameter int RECALL_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              pwr_fail,
  input  logic              pwr_good,
  input  logic              sw_store,
  output logic              busy,
  output logic              dirty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(STORE_CYC + RECALL_CYC + 1);
  localparam int ST_A  = STORE_CYC / 2;
  localparam int ST_B  = STORE_CYC - ST_A;
  localparam int RC_A  = RECALL_CYC / 2;
  localparam int RC_B  = RECALL_CYC - RC_A;

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_PROG, S_CLEAR, S_COPY} state_t;

  logic [DEPTH-1:0][DATA_W-1:0] work_q, shadow_q;
  state_t           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dirty_q, rcl_pend_q, pf_q, pg_q;

  wire idle      = (state_q == S_IDLE);
  wire last      = (cnt_q == '0);
  wire pf_rise   = pwr_fail & ~pf_q;
  wire pg_rise   = pwr_good & ~pg_q;
  wire wr_ok     = idle & host_en & host_we;
  wire go_recall = idle & (pg_rise | rcl_pend_q);
  wire go_auto   = idle & ~go_recall & pf_rise & dirty_q;
  wire go_sw     = idle & ~go_recall & ~go_auto & sw_store;

  assign busy       = ~idle;
  assign dirty      = dirty_q;
  assign host_rdata = (idle && host_en && !host_we) ? work_q[host_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_CLEAR;
      cnt_q      <= CNT_W'(RC_A - 1);
      dirty_q    <= 1'b0;
      rcl_pend_q <= 1'b0;
      pf_q       <= 1'b1;
      pg_q       <= 1'b1;
    end else begin
      pf_q <= pwr_fail;
      pg_q <= pwr_good;
      if (go_recall)          rcl_pend_q <= 1'b0;
      else if (busy && pg_rise) rcl_pend_q <= 1'b1;
      case (state_q)
        S_IDLE: begin
          if (wr_ok) dirty_q <= 1'b1;
          if (go_recall) begin
            state_q <= S_CLEAR;
            cnt_q   <= CNT_W'(RC_A - 1);
          end else if (go_auto || go_sw) begin
            state_q <= S_ERASE;
            cnt_q   <= CNT_W'(ST_A - 1);
          end
        end
        S_ERASE: begin
          if (last) begin
            state_q <= S_PROG;
            cnt_q   <= CNT_W'(ST_B - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_CLEAR: begin
          if (last) begin
            state_q <= S_COPY;
            cnt_q   <= CNT_W'(RC_B - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_PROG, S_COPY: begin
          if (last) begin
            state_q <= S_IDLE;
            dirty_q <= 1'b0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok)                      work_q[host_addr] <= host_wdata;
    if (state_q == S_CLEAR && last) work_q   <= '0;
    if (state_q == S_COPY  && last) work_q   <= shadow_q;
    if (state_q == S_ERASE && last) shadow_q <= '0;
    if (state_q == S_PROG  && last) shadow_q <= work_q;
  end

  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 1'b1 : '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == CNT_W'(STORE_CYC) || run_q == CNT_W'(RECALL_CYC))); // R11
  AST_BUSY_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && host_en && host_we) |=> work_q[$past(host_addr)] == $past(work_q[host_addr])); // R3
  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && host_en && host_we) |=> dirty_q); // R4
  AST_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !dirty_q); // R4
  AST_CLEAN_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pf_rise && !dirty_q && !sw_store && !pg_rise && !rcl_pend_q) |=> !busy); // R6
  AST_RECALL_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CLEAR || state_q == S_COPY) |=> $stable(shadow_q)); // R8
  AST_RECALL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_COPY && last) |=> work_q == shadow_q); // R8
  AST_RECALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pg_rise) |=> rcl_pend_q); // R9
endmodule

// File: tb/shadow_mem_ctrl_tb.sv
module shadow_mem_ctrl_tb;
  localparam int AW = 4, DW = 8, SC = 40, RC = 6;

  logic clk = 0, rst_n = 0;
  logic host_en = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic pwr_fail = 0, pwr_good = 0, sw_store = 0, busy, dirty;

  shadow_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SC), .RECALL_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pwr_fail(pwr_fail), .pwr_good(pwr_good), .sw_store(sw_store),
    .busy(busy), .dirty(dirty));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [16];

  // {we, addr, data, expected read}
  localparam logic [20:0] VEC [14] = '{
    {1'b1, 4'h0, 8'h11, 8'h00}, {1'b1, 4'h3, 8'hA5, 8'h00},
    {1'b1, 4'h7, 8'h3C, 8'h00}, {1'b1, 4'hF, 8'hFF, 8'h00},
    {1'b0, 4'h0, 8'h00, 8'h11}, {1'b0, 4'h3, 8'h00, 8'hA5},
    {1'b0, 4'h7, 8'h00, 8'h3C}, {1'b0, 4'hF, 8'h00, 8'hFF},
    {1'b1, 4'h3, 8'h5A, 8'h00}, {1'b0, 4'h3, 8'h00, 8'h5A},
    {1'b0, 4'h1, 8'h00, 8'h08}, {1'b0, 4'hE, 8'h00, 8'h63},
    {1'b1, 4'h9, 8'h00, 8'h00}, {1'b0, 4'h9, 8'h00, 8'h00}};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    do begin step(); n++; end while (busy && n < 1000);
    if (n >= 1000) check("watchdog busy", 1, 0);
  endtask

  task automatic write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    step();
    host_en = 0; host_we = 0;
  endtask

  task automatic read_chk(string tag, input logic [AW-1:0] a, input logic [DW-1:0] e);
    host_en = 1; host_we = 0; host_addr = a;
    #1 check(tag, host_rdata, e);
    host_en = 0;
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < 16; a++) read_chk(tag, AW'(a), model[a]);
  endtask

  initial begin
    #(200000 * 10);
    check("watchdog global", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state
    repeat (3) step();
    check("R1 busy in reset", busy, 1);
    check("R1 dirty in reset", dirty, 0);
    rst_n = 1;
    wait_idle(n);
    check("R1 R11 power-up recall length", n, RC);

    // R2 idle read with host_en low
    host_addr = 0; #1 check("R2 rdata when not reading", host_rdata, 0);

    for (int a = 0; a < 16; a++) begin
      write(AW'(a), DW'(a * 7 + 1));
      model[a] = DW'(a * 7 + 1);
    end
    check("R4 dirty after write", dirty, 1);

    // R2 vector table
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][20]) begin
        host_en = 1; host_we = 1; host_addr = VEC[i][19:16]; host_wdata = VEC[i][15:8];
        #1 check("R2 rdata during write", host_rdata, 0);
        step();
        host_en = 0; host_we = 0;
        model[VEC[i][19:16]] = VEC[i][15:8];
      end else begin
        read_chk("R2 table read", VEC[i][19:16], VEC[i][7:0]);
        check("R2 model agrees", VEC[i][7:0], model[VEC[i][19:16]]);
      end
    end

    // R5 auto store when dirty
    pwr_fail = 1;
    wait_idle(n);
    pwr_fail = 0;
    check("R5 R11 auto store length", n, SC + 1);
    check("R4 dirty cleared by store", dirty, 0);

    // R7 software store while clean, R3 blocked access, R9 dropped second request
    sw_store = 1; host_en = 1; host_we = 0; host_addr = 0;
    step();
    sw_store = 0;
    check("R7 store starts while clean", busy, 1);
    #1 check("R3 read while busy", host_rdata, 0);
    host_we = 1; host_addr = 2; host_wdata = 8'hEE; sw_store = 1;
    step();
    sw_store = 0;
    wait_idle(n);
    host_en = 0; host_we = 0;
    check("R7 R11 sw store length", n + 2, SC + 1);
    check("R3 dirty after blocked writes", dirty, 0);
    read_chk("R3 write dropped while busy", 2, model[2]);
    step(); step();
    check("R9 sw_store during busy dropped", busy, 0);

    // R6 auto store skipped when clean
    pwr_fail = 1;
    step();
    check("R6 no store when clean", busy, 0);
    step();
    pwr_fail = 0;
    check("R6 still idle", busy, 0);

    // R8 recall discards unstored writes
    write(5, 8'h99);
    pwr_good = 1;
    wait_idle(n);
    pwr_good = 0;
    check("R8 R11 recall length", n, RC + 1);
    read_chk("R8 unstored write lost", 5, model[5]);
    check("R4 dirty cleared by recall", dirty, 0);
    step();
    pwr_good = 1;
    wait_idle(n);
    pwr_good = 0;
    read_all("R8 shadow unchanged by recall");

    // R1 reset again restores stored data
    rst_n = 0;
    step(); step();
    check("R1 busy in second reset", busy, 1);
    rst_n = 1;
    wait_idle(n);
    check("R1 second power-up length", n, RC);
    read_all("R1 power-up restores shadow");

    // R9 recall held during store
    write(1, 8'h42);
    model[1] = 8'h42;
    sw_store = 1;
    step();
    sw_store = 0;
    step();
    pwr_good = 1;
    step();
    pwr_good = 0;
    wait_idle(n);
    check("R9 one idle cycle after store", busy, 0);
    step();
    check("R9 held recall starts", busy, 1);
    wait_idle(n);
    check("R9 R11 held recall length", n, RC);
    read_chk("R9 stored value after recall", 1, 8'h42);

    // R10 recall wins over auto store
    write(4, 8'h77);
    pwr_fail = 1; pwr_good = 1;
    wait_idle(n);
    pwr_fail = 0; pwr_good = 0;
    check("R10 recall chosen length", n, RC + 1);
    read_chk("R10 recall discarded write", 4, model[4]);
    step(); step();
    check("R10 losing store dropped", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule